// File: doc/BRIEF.md
# SPI Controller Interrupt and Soft-Reset Register Block

This block sits beside an SPI controller. It collects the controller's interrupt events, which arrive as one-cycle pulses, and latches each one into a sticky status register. The status register is masked by a per-source enable register and by a single global gate bit. The result drives one level-sensitive interrupt line. Software acknowledges an interrupt by writing back the status word it read, and every bit written as one is cleared.

A separate keyed register lets software reset the attached SPI core. Writing the key word `0x0000000A` starts a small sequencer with two states. `RS_IDLE` is the resting state. On an accepted key write, the transition `RS_IDLE -> RS_PULSE` is taken. `RS_PULSE` drives the core reset output for exactly one cycle. It also holds the interrupt registers cleared, and then takes `RS_PULSE -> RS_IDLE` unconditionally. The soft reset also clears the status, enable and global gate registers.

All access goes through a simple word-addressed register bus with separate read and write strobes. Register selects on `bus_addr_i` are: 0 status, 1 per-source enable, 2 global gate, 3 soft-reset key.

Top module: `spi_irq_regs`

## Requirements
- R1: Source bit positions in the status and enable registers are fixed as follows: bit 0 mode fault, bit 1 slave mode fault, bit 2 TX empty, bit 3 TX underrun, bit 4 RX full, bit 5 RX overrun. A pulse on `event_i[n]` sets status bit n, which reads back at select 0.
- R2: A status bit stays set until cleared, whatever the value of its enable bit.
- R3: A write to select 0 clears every status bit whose data bit is one, and leaves the others unchanged.
- R4: If an event and a clear hit the same status bit in the same cycle, the bit ends set.
- R5: `irq_o` is high exactly when the global gate is set and at least one status bit has its enable bit set. It follows register state in the cycle after the edge that changed it.
- R6: Select 1 holds the six enable bits in data bits 5:0. Select 2 holds the global gate in data bit 31.
- R7: A write of exactly `0x0000000A` to select 3 in state `RS_IDLE` drives `core_rst_o` high for exactly the one cycle after the write edge.
- R8: A write of any other value to select 3, or a key write made while `RS_PULSE` is active, produces no pulse and changes no register.
- R9: An accepted soft reset clears status, enable and global gate at the write edge. An event arriving during the `RS_PULSE` cycle is dropped.
- R10: `bus_rdata_o` is registered. It shows, in the cycle after a read strobe, the value selected before that edge. Unused bits read zero, and select 3 reads as zero.
- R11: After hardware reset, all registers are zero, `irq_o` is low and `core_rst_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| event_i | input | SRC_N | One-cycle event pulses from the SPI engine |
| bus_addr_i | input | 2 | Register select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level interrupt request |
| core_rst_o | output | 1 | One-cycle reset pulse to the SPI core |

## Verification
Every register write and event lands on the edge that follows it. `irq_o` and `core_rst_o` are due in the cycle right after that edge. Read data is due one edge after the read strobe and carries the pre-edge value. The bench drives each stimulus after a falling edge, advances the reference model at the next rising edge, and compares every output at the falling edge after that. Each comparison therefore falls exactly one register stage after its cause. Directed sequences cover collisions between clears, events and soft resets, and a seeded random run then mixes all accesses.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int unsigned IRQ_SRC_N = 6;

    // Source bit positions, decoded by software handlers
    localparam int unsigned SRC_MODE_FAULT  = 0;
    localparam int unsigned SRC_SLAVE_FAULT = 1;
    localparam int unsigned SRC_TX_EMPTY    = 2;
    localparam int unsigned SRC_TX_UNDERRUN = 3;
    localparam int unsigned SRC_RX_FULL     = 4;
    localparam int unsigned SRC_RX_OVERRUN  = 5;

    localparam int unsigned REG_COUNT = 4;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_ENABLE = 2'd1,
        REG_GLOBAL = 2'd2,
        REG_RESET  = 2'd3
    } reg_sel_e;

    typedef enum logic {
        RS_IDLE  = 1'b0,
        RS_PULSE = 1'b1
    } rst_state_e;

endpackage

// File: rtl/spi_irq_decode.sv
module spi_irq_decode
    import spi_irq_pkg::*;
#(
    parameter int unsigned SEL_W = 2
) (
    input  logic [SEL_W-1:0]     addr_i,
    input  logic                 wr_i,
    output logic [REG_COUNT-1:0] wr_sel_o
);

    // One write strobe per register select
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_sel
        assign wr_sel_o[g] = wr_i && (addr_i == SEL_W'(g));
    end

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status #(
    parameter int unsigned SRC_N   = 6,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned GIE_BIT = 31
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sclr_i,
    input  logic [SRC_N-1:0]  event_i,
    input  logic              wr_status_i,
    input  logic              wr_enable_i,
    input  logic              wr_global_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [SRC_N-1:0]  status_o,
    output logic [SRC_N-1:0]  enable_o,
    output logic              gie_o
);

    logic [SRC_N-1:0] status_q, enable_q;
    logic             gie_q;
    logic [SRC_N-1:0] clr_vec;

    assign clr_vec = wr_status_i ? wdata_i[SRC_N-1:0] : '0;

    // Sticky status: a clear removes the bit, and an event in the same cycle sets it back
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            status_q <= '0;
        end else if (sclr_i) begin
            status_q <= '0;
        end else begin
            status_q <= (status_q & ~clr_vec) | event_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            enable_q <= '0;
            gie_q    <= 1'b0;
        end else if (sclr_i) begin
            enable_q <= '0;
            gie_q    <= 1'b0;
        end else begin
            if (wr_enable_i) enable_q <= wdata_i[SRC_N-1:0];
            if (wr_global_i) gie_q    <= wdata_i[GIE_BIT];
        end
    end

    assign status_o = status_q;
    assign enable_o = enable_q;
    assign gie_o    = gie_q;

    AST_STICKY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sclr_i && !wr_status_i) |=> ((status_q & $past(status_q)) == $past(status_q))); // R2

    AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sclr_i && (event_i != '0)) |=> ((status_q & $past(event_i)) == $past(event_i))); // R4

endmodule

// File: rtl/spi_irq_softrst.sv
module spi_irq_softrst
    import spi_irq_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter logic [DATA_W-1:0] RESET_KEY = DATA_W'(32'h0000_000A)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              pulse_o,
    output logic              sclr_o
);

    rst_state_e state_q, state_d;
    logic       key_ok;

    assign key_ok = key_wr_i && (wdata_i == RESET_KEY) && (state_q == RS_IDLE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE:  if (key_ok) state_d = RS_PULSE;
            RS_PULSE: state_d = RS_IDLE;
            default:  state_d = RS_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= RS_IDLE;
        else         state_q <= state_d;
    end

    // Outputs
    always_comb begin
        pulse_o = 1'b0;
        sclr_o  = 1'b0;
        unique case (state_q)
            RS_IDLE:  sclr_o = key_ok;
            RS_PULSE: begin
                pulse_o = 1'b1;
                sclr_o  = 1'b1;
            end
            default: ;
        endcase
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o); // R7

    AST_KEY_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_wr_i && (wdata_i == RESET_KEY) && !pulse_o) |=> pulse_o); // R7

    AST_BAD_KEY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_wr_i && (wdata_i != RESET_KEY)) |=> !pulse_o); // R8

endmodule

// File: rtl/spi_irq_regs.sv
module spi_irq_regs
    import spi_irq_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned SRC_N     = IRQ_SRC_N,
    parameter int unsigned GIE_BIT   = 31,
    parameter logic [DATA_W-1:0] RESET_KEY = DATA_W'(32'h0000_000A)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SRC_N-1:0]  event_i,
    input  logic [1:0]        bus_addr_i,
    input  logic              bus_wr_i,
    input  logic              bus_rd_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              core_rst_o
);

    localparam int unsigned PAD_W = DATA_W - SRC_N;

    logic [REG_COUNT-1:0] wr_sel;
    logic [SRC_N-1:0]     status, enable;
    logic                 gie, sclr;
    logic [DATA_W-1:0]    rd_mux, rdata_q;

    spi_irq_decode #(.SEL_W(2)) u_decode (
        .addr_i   (bus_addr_i),
        .wr_i     (bus_wr_i),
        .wr_sel_o (wr_sel)
    );

    spi_irq_status #(.SRC_N(SRC_N), .DATA_W(DATA_W), .GIE_BIT(GIE_BIT)) u_status (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .sclr_i      (sclr),
        .event_i     (event_i),
        .wr_status_i (wr_sel[REG_STATUS]),
        .wr_enable_i (wr_sel[REG_ENABLE]),
        .wr_global_i (wr_sel[REG_GLOBAL]),
        .wdata_i     (bus_wdata_i),
        .status_o    (status),
        .enable_o    (enable),
        .gie_o       (gie)
    );

    spi_irq_softrst #(.DATA_W(DATA_W), .RESET_KEY(RESET_KEY)) u_softrst (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .key_wr_i (wr_sel[REG_RESET]),
        .wdata_i  (bus_wdata_i),
        .pulse_o  (core_rst_o),
        .sclr_o   (sclr)
    );

    // Read selection; the key register reads as zero
    always_comb begin
        rd_mux = '0;
        unique case (reg_sel_e'(bus_addr_i))
            REG_STATUS: rd_mux = {{PAD_W{1'b0}}, status};
            REG_ENABLE: rd_mux = {{PAD_W{1'b0}}, enable};
            REG_GLOBAL: rd_mux[GIE_BIT] = gie;
            REG_RESET:  rd_mux = '0;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       rdata_q <= '0;
        else if (bus_rd_i) rdata_q <= rd_mux;
    end

    assign bus_rdata_o = rdata_q;
    assign irq_o       = gie && ((status & enable) != '0);

    AST_SOFT_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        core_rst_o |-> (status == '0 && enable == '0 && !gie)); // R9

    AST_IRQ_QUIET_NO_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status == '0) |-> !irq_o); // R5

endmodule

// File: tb/spi_irq_regs_test.sv
module spi_irq_regs_test;

    localparam logic [31:0] KEY = 32'h0000_000A;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  event_i = '0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0, rd = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, core_rst;

    int checks = 0, fails = 0;
    logic [5:0] m_st = '0, m_en = '0;
    logic       m_gie = 1'b0, m_pulse = 1'b0;

    always #4 clk = ~clk;

    spi_irq_regs uut (
        .clk_i(clk), .rst_ni(rst_n), .event_i(event_i), .bus_addr_i(addr),
        .bus_wr_i(wr), .bus_rd_i(rd), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .core_rst_o(core_rst)
    );

    function automatic logic [5:0] next_status(logic [5:0] st, logic [5:0] ev, logic [5:0] clr);
        return (st & ~clr) | ev;
    endfunction

    function automatic logic [31:0] read_model(logic [1:0] a);
        case (a)
            2'd0:    return {26'b0, m_st};
            2'd1:    return {26'b0, m_en};
            2'd2:    return {m_gie, 31'b0};
            default: return 32'b0;
        endcase
    endfunction

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic cyc(input logic [5:0] ev, input logic w, input logic r,
                       input logic [1:0] a, input logic [31:0] d, input string tag);
        logic [31:0] exp_rd;
        logic        key;
        event_i = ev; wr = w; rd = r; addr = a; wdata = d;
        exp_rd = read_model(a);
        key = w && (a == 2'd3) && (d == KEY) && !m_pulse;
        @(posedge clk);
        if (key || m_pulse) begin
            m_st = '0; m_en = '0; m_gie = 1'b0;
        end else begin
            m_st = next_status(m_st, ev, (w && a == 2'd0) ? d[5:0] : 6'h0);
            if (w && a == 2'd1) m_en = d[5:0];
            if (w && a == 2'd2) m_gie = d[31];
        end
        m_pulse = key;
        @(negedge clk);
        event_i = '0; wr = 1'b0; rd = 1'b0;
        check({31'b0, irq}, {31'b0, m_gie && ((m_st & m_en) != 0)}, "R5 irq level");
        check({31'b0, core_rst}, {31'b0, m_pulse}, "R7 reset pulse");
        if (r) check(rdata, exp_rd, tag);
    endtask

    task automatic rd_expect(input logic [1:0] a, input logic [31:0] exp, input string tag);
        cyc(6'h0, 1'b0, 1'b1, a, 32'h0, tag);
        check(rdata, exp, tag);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        check({30'b0, irq, core_rst}, 32'h0, "R11 outputs after reset");
        rd_expect(2'd0, 32'h0, "R11 status reset");
        rd_expect(2'd1, 32'h0, "R11 enable reset");
        rd_expect(2'd2, 32'h0, "R11 global reset");
        // R1 / R2: bit positions, sticky with enable at zero
        cyc(6'h01, 1'b0, 1'b0, 2'd0, 32'h0, "R1");
        rd_expect(2'd0, 32'h01, "R2 sticky mode fault, enable zero");
        cyc(6'h20, 1'b0, 1'b0, 2'd0, 32'h0, "R1");
        rd_expect(2'd0, 32'h21, "R1 rx overrun at bit 5");
        // R3 write-one-to-clear
        cyc(6'h0, 1'b1, 1'b0, 2'd0, 32'h01, "R3");
        rd_expect(2'd0, 32'h20, "R3 clear bit 0 only");
        // R4 event beats clear
        cyc(6'h20, 1'b1, 1'b0, 2'd0, 32'h20, "R4");
        rd_expect(2'd0, 32'h20, "R4 event wins over clear");
        // R5 / R6 gating
        cyc(6'h0, 1'b1, 1'b0, 2'd1, 32'hFFFF_FFE0, "R6");
        check({31'b0, irq}, 32'h0, "R5 no irq without global gate");
        cyc(6'h0, 1'b1, 1'b0, 2'd2, 32'h8000_0000, "R6");
        check({31'b0, irq}, 32'h1, "R5 irq with gate and enable");
        rd_expect(2'd1, 32'h20, "R6 enable readback bits 5:0");
        rd_expect(2'd2, 32'h8000_0000, "R6 global gate at bit 31");
        // R8 wrong key
        cyc(6'h0, 1'b1, 1'b0, 2'd3, 32'h0000_000B, "R8");
        check({31'b0, core_rst}, 32'h0, "R8 wrong key no pulse");
        rd_expect(2'd0, 32'h20, "R8 status unchanged after wrong key");
        rd_expect(2'd2, 32'h8000_0000, "R8 gate unchanged after wrong key");
        // R7 / R9 soft reset, event during the pulse is dropped
        cyc(6'h0, 1'b1, 1'b0, 2'd3, KEY, "R7");
        check({31'b0, core_rst}, 32'h1, "R7 pulse after key");
        check({31'b0, irq}, 32'h0, "R9 irq cleared by soft reset");
        cyc(6'h04, 1'b1, 1'b0, 2'd3, KEY, "R8");
        check({31'b0, core_rst}, 32'h0, "R7 pulse lasts one cycle; R8 key during pulse");
        rd_expect(2'd0, 32'h0, "R9 status cleared, event in pulse dropped");
        rd_expect(2'd1, 32'h0, "R9 enable cleared");
        rd_expect(2'd2, 32'h0, "R9 gate cleared");
        rd_expect(2'd3, 32'h0, "R10 key register reads zero");
        // Seeded random mix
        for (int i = 0; i < 4000; i++) begin
            logic [5:0]  ev;
            logic [1:0]  a;
            logic [31:0] d;
            ev = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h0;
            a  = 2'($urandom_range(0, 3));
            d  = $urandom;
            if (a == 2'd3) d = ($urandom_range(0, 7) == 0) ? KEY : {d[31:4], 4'hB};
            cyc(ev, ($urandom_range(0, 9) < 3), ($urandom_range(0, 9) < 4), a, d, "R10 random read");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule